// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This peripheral holds two independent down-counters. Each one loads a 24-bit start value, counts it down on a slowed-down version of the system clock, and reports reaching the end of its count. Each channel has its own control word, which selects running or halted, interrupt enable, periodic or single-run behaviour, and a clock divide ratio. Each channel also has its own start-value register. A shared status word latches one bit for each channel when that channel expires. Software clears those bits by writing ones. A single interrupt line reports any latched bit whose channel has its interrupt enabled.

Software reaches the block through a plain synchronous register port. A write is taken on the rising clock edge when `wr_en` is high. Read data is combinational from the address. The port has no back-pressure: every write is accepted in the cycle it is presented. Channel 1's live count can be read back, so that channel can serve as a free-running time base. Channel 0 serves as an event timer.

Top module: `duo_countdown_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither counter advances.
- R2: Byte offsets: channel 0 control 0x00, channel 1 control 0x04, channel 0 start value 0x08, channel 1 start value 0x0C, channel 1 live count 0x14, status 0x18. Any other offset reads zero, and each register is written only at its own offset.
- R3: Control bit layout is run = bit 30, interrupt enable = bit 29, periodic = bit 27, and divide value = bits [7:0]. All other control bits read zero. Start-value registers keep only bits [23:0], so a write of all ones reads back 0xFFFFFF.
- R4: With divide value P and start value N, a running channel decrements once every P+1 clocks. It expires on the clock edge N*(P+1) cycles after the edge that took the starting control write.
- R5: A control write that sets run while run is clear and the count is zero loads the count from the start-value register. In single-run mode (bit 27 clear), expiry leaves the count at zero and clears run.
- R6: In periodic mode, expiry reloads the count from the start-value register and run stays set.
- R7: Clearing run freezes the count. Setting run again with a nonzero count resumes from the frozen value without reloading. A clock that takes a control write does not advance that channel.
- R8: A start-value write to a running channel leaves the current count alone and is used at the next reload.
- R9: Expiry sets status bit 1 for channel 1 and bit 0 for channel 0. Writing 1 to a status bit clears it, and writing 0 leaves it. Status bits above bit 1 read zero.
- R10: `irq` is high exactly when some status bit is set while that channel's interrupt enable is set.
- R11: Offset 0x14 returns channel 1's current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check several things on every cycle for channel 1. A single-run expiry must be followed by a zero count and a cleared run bit. A periodic expiry must be followed by a reload of the start value. Any expiry must latch status. A halted channel's count must not move, and a running count may drop by at most one per clock. The interrupt must never be raised without a latched status bit. Other behaviours can only be shown by the bench's scenarios. These are the exact expiry cycle for each divide value, reading back the register layout, the point at which a start value written mid-period takes effect, and write-one-to-clear selectivity with interrupt masking on channel 0.

// File: rtl/dct_pkg.sv
package dct_pkg;
  // Control word bit positions (decoded by software)
  localparam int unsigned BIT_RUN = 30;
  localparam int unsigned BIT_IE  = 29;
  localparam int unsigned BIT_PER = 27;
  // Register byte offsets
  localparam int unsigned OFS_CTL0  = 'h00;
  localparam int unsigned OFS_CTL1  = 'h04;
  localparam int unsigned OFS_LOAD0 = 'h08;
  localparam int unsigned OFS_LOAD1 = 'h0C;
  localparam int unsigned OFS_LIVE1 = 'h14;
  localparam int unsigned OFS_STAT  = 'h18;
  localparam int unsigned NUM_CH    = 2;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run && !hold) begin
      if (phase_q == div) phase_q <= '0;
      else                phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && !hold && !restart && (phase_q == div);
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             w_run,
  input  logic             w_ie,
  input  logic             w_per,
  input  logic [PRE_W-1:0] w_div,
  input  logic             load_we,
  input  logic [CNT_W-1:0] w_load,
  output logic             run_q,
  output logic             ie_q,
  output logic             per_q,
  output logic [PRE_W-1:0] div_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic start_load;
  logic tick;

  assign start_load = ctl_we && w_run && !run_q && (cnt_q == '0);

  dct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .hold    (ctl_we),
    .restart (start_load),
    .div     (div_q),
    .tick    (tick)
  );

  assign expire = tick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      per_q <= 1'b0;
      div_q <= '0;
      cnt_q <= '0;
    end else if (ctl_we) begin
      run_q <= w_run;
      ie_q  <= w_ie;
      per_q <= w_per;
      div_q <= w_div;
      if (start_load) cnt_q <= load_q;
    end else if (tick) begin
      if (expire) begin
        if (per_q) begin
          cnt_q <= load_q;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (load_we) load_q <= w_load;
  end
endmodule

// File: rtl/dct_status.sv
module dct_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] expire,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] ie,
  output logic [N-1:0] stat_q,
  output logic         irq
);
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | expire;
  end

  assign irq = |(stat_q & ie);
endmodule

// File: rtl/duo_countdown_timer.sv
module duo_countdown_timer #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import dct_pkg::*;

  localparam int unsigned NCH = NUM_CH;

  logic [NCH-1:0]   ctl_we_v, load_we_v, run_v, ie_v, per_v, exp_v;
  logic [PRE_W-1:0] div_v  [NCH];
  logic [CNT_W-1:0] load_v [NCH];
  logic [CNT_W-1:0] cnt_v  [NCH];
  logic [NCH-1:0]   stat_q;
  logic             stat_we;
  logic             unused_wdata;

  assign unused_wdata = ^{wr_data[DATA_W-1:BIT_RUN+1], wr_data[BIT_PER-1:CNT_W],
                          wr_data[BIT_IE-1:BIT_PER+1]};

  assign stat_we = wr_en && (addr == ADDR_W'(OFS_STAT));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ctl_we_v[i]  = wr_en && (addr == ADDR_W'(OFS_CTL0 + 4 * i));
    assign load_we_v[i] = wr_en && (addr == ADDR_W'(OFS_LOAD0 + 4 * i));

    dct_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl_we  (ctl_we_v[i]),
      .w_run   (wr_data[BIT_RUN]),
      .w_ie    (wr_data[BIT_IE]),
      .w_per   (wr_data[BIT_PER]),
      .w_div   (wr_data[PRE_W-1:0]),
      .load_we (load_we_v[i]),
      .w_load  (wr_data[CNT_W-1:0]),
      .run_q   (run_v[i]),
      .ie_q    (ie_v[i]),
      .per_q   (per_v[i]),
      .div_q   (div_v[i]),
      .load_q  (load_v[i]),
      .cnt_q   (cnt_v[i]),
      .expire  (exp_v[i])
    );
  end

  dct_status #(.N(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (exp_v),
    .clr_we   (stat_we),
    .clr_bits (wr_data[NCH-1:0]),
    .ie       (ie_v),
    .stat_q   (stat_q),
    .irq      (irq)
  );

  function automatic logic [DATA_W-1:0] ctl_word(input logic r, input logic e,
                                                 input logic p,
                                                 input logic [PRE_W-1:0] d);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_RUN] = r;
    w[BIT_IE]  = e;
    w[BIT_PER] = p;
    w[PRE_W-1:0] = d;
    return w;
  endfunction

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFS_CTL0))
      rd_data = ctl_word(run_v[0], ie_v[0], per_v[0], div_v[0]);
    else if (addr == ADDR_W'(OFS_CTL1))
      rd_data = ctl_word(run_v[1], ie_v[1], per_v[1], div_v[1]);
    else if (addr == ADDR_W'(OFS_LOAD0))
      rd_data[CNT_W-1:0] = load_v[0];
    else if (addr == ADDR_W'(OFS_LOAD1))
      rd_data[CNT_W-1:0] = load_v[1];
    else if (addr == ADDR_W'(OFS_LIVE1))
      rd_data[CNT_W-1:0] = cnt_v[1];
    else if (addr == ADDR_W'(OFS_STAT))
      rd_data[NCH-1:0] = stat_q;
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [1:0]       stat,
  input logic             run1,
  input logic             per1,
  input logic             exp1,
  input logic             ctl_we1,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] load1
);
  // R5: single-run expiry halts at zero
  a_r5_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (exp1 && !per1) |=> (cnt1 == '0 && !run1));

  // R6: periodic expiry reloads and keeps running
  a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (exp1 && per1) |=> (cnt1 == $past(load1) && run1));

  // R9: expiry latches status bit 1
  a_r9_status_latch: assert property (@(posedge clk) disable iff (!rst_n)
    exp1 |=> stat[1]);

  // R7: halted channel with no control write keeps its count
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run1 && !ctl_we1) |=> $stable(cnt1));

  // R4: a running count above one drops by at most one per clock
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run1 && !ctl_we1 && cnt1 > CNT_W'(1)) |=>
      (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) - 1'b1));

  // R10: interrupt implies a latched status bit
  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != 2'b00));
endmodule

bind duo_countdown_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .stat    (stat_q),
  .run1    (run_v[1]),
  .per1    (per_v[1]),
  .exp1    (exp_v[1]),
  .ctl_we1 (ctl_we_v[1]),
  .cnt1    (cnt_v[1]),
  .load1   (load_v[1])
);

// File: tb/tb_duo_countdown_timer.sv
module tb_duo_countdown_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  duo_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {divide[7:0], start value[23:0], expected cycles to expiry[15:0]}
  localparam logic [47:0] VEC [0:5] = '{
    48'h00_000001_0001, 48'h00_000005_0005, 48'h03_000004_0010,
    48'h01_000007_000E, 48'h07_000002_0010, 48'h02_000003_0009
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state; R2 offsets all readable
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], v); check("R1 reset read", v, 32'h0);
    end
    check("R1 irq low", {31'h0, irq}, 32'h0);
    wait_n(3); rd(5'h14, v); check("R1 counter idle", v, 32'h0);

    // R3 bit layout and masking; R2 decode separation
    wr(5'h04, 32'hBFFF_FFFF);
    rd(5'h04, v); check("R3 control readback", v, 32'h2800_00FF);
    rd(5'h00, v); check("R2 ctl0 untouched", v, 32'h0);
    wr(5'h08, 32'hFF12_3456);
    rd(5'h08, v); check("R3 load0 masked", v, 32'h0012_3456);
    rd(5'h0C, v); check("R2 load1 untouched", v, 32'h0);
    rd(5'h10, v); check("R2 unmapped zero", v, 32'h0);
    wr(5'h04, 32'h0);

    // R4/R5/R11: single-run expiry timing across divide values
    foreach (VEC[i]) begin
      logic [7:0]  p;
      logic [23:0] n;
      int          c;
      p = VEC[i][47:40]; n = VEC[i][39:16]; c = int'(VEC[i][15:0]);
      wr(5'h18, 32'h1F);
      wr(5'h0C, {8'h0, n});
      wr(5'h04, 32'h4000_0000 | {24'h0, p});
      rd(5'h14, v); check("R5 start loads count (R11 live read)", v, {8'h0, n});
      wait_n(c - 1);
      rd(5'h18, v); check("R4 no expiry before N*(P+1)", v, 32'h0);
      wait_n(1);
      rd(5'h18, v); check("R4 expiry at N*(P+1)", v, 32'h2);
      rd(5'h14, v); check("R5 count stays zero", v, 32'h0);
      rd(5'h04, v); check("R5 run cleared", v, {24'h0, p});
    end

    // R7: freeze and resume
    do_reset();
    wr(5'h0C, 32'd10);
    wr(5'h04, 32'h4000_0000);
    wait_n(3);
    rd(5'h14, v); check("R7 counting before freeze", v, 32'd7);
    wr(5'h04, 32'h0);
    rd(5'h14, v); check("R7 frozen at stop", v, 32'd7);
    wait_n(5);
    rd(5'h14, v); check("R7 still frozen", v, 32'd7);
    wr(5'h04, 32'h4000_0000);
    rd(5'h14, v); check("R7 resume without reload", v, 32'd7);
    wait_n(2);
    rd(5'h14, v); check("R7 resumed count", v, 32'd5);
    wait_n(5);
    rd(5'h18, v); check("R7 resumed to expiry", v, 32'h2);

    // R6 + R9: periodic reload and write-one-to-clear
    do_reset();
    wr(5'h0C, 32'd3);
    wr(5'h04, 32'h4800_0000);
    wait_n(1);
    rd(5'h14, v); check("R6 decrement", v, 32'd2);
    wait_n(2);
    rd(5'h14, v); check("R6 reload on expiry", v, 32'd3);
    rd(5'h18, v); check("R9 channel1 sets bit1", v, 32'h2);
    rd(5'h04, v); check("R6 run stays set", v, 32'h4800_0000);
    wr(5'h18, 32'h2);
    rd(5'h18, v); check("R9 cleared by writing 1", v, 32'h0);
    wait_n(2);
    rd(5'h18, v); check("R6 next period expiry", v, 32'h2);

    // R8: start value written mid-period applies at reload
    do_reset();
    wr(5'h0C, 32'd4);
    wr(5'h04, 32'h4800_0000);
    wr(5'h0C, 32'd2);
    rd(5'h14, v); check("R8 current count unaffected", v, 32'd3);
    wait_n(3);
    rd(5'h14, v); check("R8 new value at reload", v, 32'd2);

    // R10 + R9: channel 0 status, masking and selective clear
    do_reset();
    wr(5'h08, 32'd2);
    wr(5'h00, 32'h4000_0000);
    wait_n(2);
    rd(5'h18, v); check("R9 channel0 sets bit0", v, 32'h1);
    check("R10 irq masked", {31'h0, irq}, 32'h0);
    wr(5'h00, 32'h2000_0000);
    check("R10 irq when enabled", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h2);
    rd(5'h18, v); check("R9 writing 0 keeps bit0", v, 32'h1);
    check("R10 irq held", {31'h0, irq}, 32'h1);
    wr(5'h18, 32'h1F);
    rd(5'h18, v); check("R9 all cleared", v, 32'h0);
    check("R10 irq drops", {31'h0, irq}, 32'h0);

    // R3/R11: maximum count
    do_reset();
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); check("R3 max start value", v, 32'h00FF_FFFF);
    wr(5'h04, 32'h4000_0000);
    rd(5'h14, v); check("R11 max live count", v, 32'h00FF_FFFF);
    wait_n(1);
    rd(5'h14, v); check("R11 live count moves", v, 32'h00FF_FFFE);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule